// File: doc/BRIEF.md
# Multi-Policy Control/Status Field Bank

This block is one control/status register word built from single-bit fields. Each bit is given, when the block is elaborated, one of eight access policies. The policy decides what a software write does to the bit, whether hardware set and clear strobes can change it, and whether software can read it back. Software reaches the word over a simple register bus with an address, a write enable, write data, a read enable and read data. Hardware logic drives one set strobe and one clear strobe per bit, and it sees the current value of every bit on `field_q`.

Status flags, interrupt-style sticky bits, software "go" bits that hardware acknowledges, and plain configuration bits can all share one word, because each bit carries its own policy. The policy codes are packed three bits per field into the `POLICY` parameter. The reset values come from `RST_VAL`. The word answers at address `REG_ADDR`.

Top module: `csrbank_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `field_q` takes its `RST_VAL` bit. With the default parameters, `field_q` is 8'h05 after reset.
- R2: A write changes fields only when `wr_en` is high and `addr` equals `REG_ADDR` (default 4'h3). `rd_data` is combinational. It shows the readable field values while `rd_en` is high and `addr` equals `REG_ADDR`, and it is 0 in every other case.
- R3: Policy code 0, hardware status (default bit 0): software writes have no effect. `hw_set` makes the bit 1 and `hw_clr` makes it 0. When both strobes are high, set wins.
- R4: Policy code 1, plain read/write (default bit 1): a software write loads the written bit value. Both hardware strobes are ignored.
- R5: Policy code 2, read/write with hardware clear (default bit 2): a software write loads the written value. `hw_clr` makes the bit 0 unless a software write happens in the same cycle, in which case the write wins. `hw_set` is ignored.
- R6: Policy code 3, read/write with hardware set and clear (default bit 3): `hw_set` makes the bit 1 and overrides everything else. Otherwise a software write loads the written value. Otherwise `hw_clr` makes the bit 0.
- R7: Policy code 4, hardware set with write-one-to-clear (default bit 4): `hw_set` makes the bit 1. A software write of 1 clears it unless `hw_set` is high in the same cycle. A software write of 0 has no effect. `hw_clr` is ignored.
- R8: Policy code 5, write-one-to-set with hardware clear (default bit 5): a software write of 1 makes the bit 1 and wins over a same-cycle `hw_clr`. A software write of 0 has no effect. `hw_clr` otherwise makes the bit 0. `hw_set` is ignored.
- R9: Policy code 6, hardware set, cleared by hardware or by a software write of 1 (default bit 6): `hw_set` makes the bit 1 and wins over both kinds of clear. `hw_clr` or a software write of 1 makes it 0. A software write of 0 has no effect.
- R10: Policy code 7, write-only (default bit 7): a software write loads the written value, which then appears on `field_q`. The bit always reads back as 0 on `rd_data`. Both hardware strobes are ignored.
- R11: Every change caused by a write or a strobe in one cycle appears on `field_q` and `rd_data` after the next rising edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Register bus address |
| wr_en | input | 1 | Register bus write enable |
| wr_data | input | N_FIELDS | Register bus write data, one bit per field |
| rd_en | input | 1 | Register bus read enable |
| rd_data | output | N_FIELDS | Register bus read data, combinational |
| hw_set | input | N_FIELDS | Per-field hardware set strobe |
| hw_clr | input | N_FIELDS | Per-field hardware clear strobe |
| field_q | output | N_FIELDS | Current field values seen by the hardware |

## Verification
Some properties are checked on every clock by the bound checker, one per bit according to its policy:
- values after reset;
- zero read data on a miss or a write-only bit;
- the outcome of a set strobe;
- the outcome of a one-written clear or set;
- a loaded software value;
- the stability of a hardware-status bit when it gets no strobe.

The bench scenarios cover what a one-cycle property does not pin down. These are the ignored strobes and ignored zero writes shown at the ports, every same-cycle collision and its winner, writes to the wrong address, and the fact that an update appears only after the edge that follows its stimulus.

// File: rtl/csrbank_pkg.sv
package csrbank_pkg;

    typedef enum logic [2:0] {
        ACC_HWSTAT     = 3'd0,
        ACC_RW         = 3'd1,
        ACC_RW_HCLR    = 3'd2,
        ACC_RW_HSETCLR = 3'd3,
        ACC_HSET_W1C   = 3'd4,
        ACC_W1S_HCLR   = 3'd5,
        ACC_HSET_XCLR  = 3'd6,
        ACC_WO         = 3'd7
    } acc_e;

    localparam int unsigned ACC_CODE_W = 3;

    typedef struct packed {
        logic we;
        logic wd;
        logic hs;
        logic hc;
    } bit_evt_t;

    function automatic logic next_bit(acc_e pol, logic cur, bit_evt_t ev);
        logic one_wr;
        logic res;
        one_wr = ev.we & ev.wd;
        res    = cur;
        unique case (pol)
            ACC_HWSTAT:     res = ev.hs ? 1'b1 : (ev.hc ? 1'b0 : cur);
            ACC_RW:         res = ev.we ? ev.wd : cur;
            ACC_RW_HCLR:    res = ev.we ? ev.wd : (ev.hc ? 1'b0 : cur);
            ACC_RW_HSETCLR: res = ev.hs ? 1'b1 : (ev.we ? ev.wd : (ev.hc ? 1'b0 : cur));
            ACC_HSET_W1C:   res = ev.hs ? 1'b1 : (one_wr ? 1'b0 : cur);
            ACC_W1S_HCLR:   res = one_wr ? 1'b1 : (ev.hc ? 1'b0 : cur);
            ACC_HSET_XCLR:  res = ev.hs ? 1'b1 : ((one_wr | ev.hc) ? 1'b0 : cur);
            ACC_WO:         res = ev.we ? ev.wd : cur;
            default:        res = cur;
        endcase
        return res;
    endfunction

    function automatic logic readable(acc_e pol);
        return pol != ACC_WO;
    endfunction

endpackage

// File: rtl/csrbank_decode.sv
module csrbank_decode #(
    parameter int unsigned ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic match;

    always_comb begin
        match  = (addr == REG_ADDR);
        wr_hit = wr_en & match;
        rd_hit = rd_en & match;
    end
endmodule

// File: rtl/csrbank_bit.sv
module csrbank_bit
    import csrbank_pkg::*;
#(
    parameter acc_e POL = ACC_RW,
    parameter logic RST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_we,
    input  logic sw_wd,
    input  logic hs,
    input  logic hc,
    output logic q,
    output logic rd_bit
);
    bit_evt_t ev;

    always_comb begin
        ev.we = sw_we;
        ev.wd = sw_wd;
        ev.hs = hs;
        ev.hc = hc;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST;
        else     q <= next_bit(POL, q, ev);
    end

    generate
        if (readable(POL)) begin : g_rd
            assign rd_bit = q;
        end else begin : g_nord
            assign rd_bit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/csrbank_top.sv
module csrbank_top
    import csrbank_pkg::*;
#(
    parameter int unsigned N_FIELDS = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3,
    parameter logic [ACC_CODE_W*N_FIELDS-1:0] POLICY =
        {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    parameter logic [N_FIELDS-1:0] RST_VAL = 8'h05
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [N_FIELDS-1:0] wr_data,
    input  logic                rd_en,
    output logic [N_FIELDS-1:0] rd_data,
    input  logic [N_FIELDS-1:0] hw_set,
    input  logic [N_FIELDS-1:0] hw_clr,
    output logic [N_FIELDS-1:0] field_q
);
    logic                wr_hit;
    logic                rd_hit;
    logic [N_FIELDS-1:0] rd_bits;

    csrbank_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    generate
        for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
            csrbank_bit #(
                .POL (acc_e'(POLICY[ACC_CODE_W*i +: ACC_CODE_W])),
                .RST (RST_VAL[i])
            ) u_bit (
                .clk    (clk),
                .rst    (rst),
                .sw_we  (wr_hit),
                .sw_wd  (wr_data[i]),
                .hs     (hw_set[i]),
                .hc     (hw_clr[i]),
                .q      (field_q[i]),
                .rd_bit (rd_bits[i])
            );
        end
    endgenerate

    always_comb rd_data = rd_hit ? rd_bits : '0;
endmodule

// File: rtl/csrbank_chk.sv
module csrbank_chk
    import csrbank_pkg::*;
#(
    parameter int unsigned N_FIELDS = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3,
    parameter logic [ACC_CODE_W*N_FIELDS-1:0] POLICY = '0,
    parameter logic [N_FIELDS-1:0] RST_VAL = '0
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic [N_FIELDS-1:0] wr_data,
    input logic                rd_en,
    input logic [N_FIELDS-1:0] rd_data,
    input logic [N_FIELDS-1:0] hw_set,
    input logic [N_FIELDS-1:0] hw_clr,
    input logic [N_FIELDS-1:0] field_q
);
    logic wh;
    assign wh = wr_en && (addr == REG_ADDR);

    p_reset_value_r1: assert property (@(posedge clk) rst |=> field_q == RST_VAL);

    p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == REG_ADDR) |-> rd_data == '0);

    generate
        for (genvar i = 0; i < N_FIELDS; i++) begin : g_c
            localparam logic [2:0] C = POLICY[ACC_CODE_W*i +: ACC_CODE_W];
            if (C == 3'd0) begin : g_hw
                p_hwstat_hold_r3: assert property (@(posedge clk) disable iff (rst)
                    !hw_set[i] && !hw_clr[i] |=> $stable(field_q[i]));
            end else if (C == 3'd1) begin : g_rw
                p_rw_load_r4: assert property (@(posedge clk) disable iff (rst)
                    wh |=> field_q[i] == $past(wr_data[i]));
            end else if (C == 3'd2) begin : g_rwc
                p_rwhclr_load_r5: assert property (@(posedge clk) disable iff (rst)
                    wh |=> field_q[i] == $past(wr_data[i]));
                p_rwhclr_clear_r5: assert property (@(posedge clk) disable iff (rst)
                    !wh && hw_clr[i] |=> !field_q[i]);
            end else if (C == 3'd3) begin : g_rwsc
                p_rwsc_set_r6: assert property (@(posedge clk) disable iff (rst)
                    hw_set[i] |=> field_q[i]);
            end else if (C == 3'd4) begin : g_w1c
                p_w1c_set_r7: assert property (@(posedge clk) disable iff (rst)
                    hw_set[i] |=> field_q[i]);
                p_w1c_clear_r7: assert property (@(posedge clk) disable iff (rst)
                    !hw_set[i] && wh && wr_data[i] |=> !field_q[i]);
            end else if (C == 3'd5) begin : g_w1s
                p_w1s_set_r8: assert property (@(posedge clk) disable iff (rst)
                    wh && wr_data[i] |=> field_q[i]);
                p_w1s_clear_r8: assert property (@(posedge clk) disable iff (rst)
                    hw_clr[i] && !(wh && wr_data[i]) |=> !field_q[i]);
            end else if (C == 3'd6) begin : g_x
                p_x_set_r9: assert property (@(posedge clk) disable iff (rst)
                    hw_set[i] |=> field_q[i]);
                p_x_clear_r9: assert property (@(posedge clk) disable iff (rst)
                    !hw_set[i] && (hw_clr[i] || (wh && wr_data[i])) |=> !field_q[i]);
            end else begin : g_wo
                p_wo_load_r10: assert property (@(posedge clk) disable iff (rst)
                    wh |=> field_q[i] == $past(wr_data[i]));
                p_wo_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
                    rd_data[i] == 1'b0);
            end
        end
    endgenerate
endmodule

bind csrbank_top csrbank_chk #(
    .N_FIELDS (N_FIELDS),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .POLICY   (POLICY),
    .RST_VAL  (RST_VAL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .hw_set  (hw_set),
    .hw_clr  (hw_clr),
    .field_q (field_q)
);

// File: tb/sim_csrbank_top.sv
module sim_csrbank_top;
    localparam logic [3:0] RA = 4'h3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] hw_set = '0;
    logic [7:0] hw_clr = '0;
    logic [7:0] field_q;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    csrbank_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .hw_set(hw_set), .hw_clr(hw_clr),
        .field_q(field_q)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(logic [3:0] a, logic we, logic [7:0] wd, logic [7:0] hs, logic [7:0] hc);
        @(negedge clk);
        addr = a; wr_en = we; wr_data = wd; hw_set = hs; hw_clr = hc;
        @(posedge clk);
        #1;
        wr_en = 1'b0; hw_set = '0; hw_clr = '0; wr_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic en, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = en;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        check("R1 field_q after reset", field_q, 8'h05);
        rd(RA, 1'b1, v);
        check("R1 read after reset", v, 8'h05);
    endtask

    task automatic t_addr();
        logic [7:0] v;
        do_reset();
        step(4'h4, 1'b1, 8'hFF, 8'h00, 8'h00);
        check("R2 write to other address", field_q, 8'h05);
        rd(4'h2, 1'b1, v);
        check("R2 read other address", v, 8'h00);
        rd(RA, 1'b0, v);
        check("R2 no rd_en", v, 8'h00);
    endtask

    task automatic t_hwstat();
        do_reset();
        step(RA, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R3 write ignored", {7'd0, field_q[0]}, 8'h01);
        step(RA, 1'b0, 8'h00, 8'h00, 8'h01);
        check("R3 hw clear", {7'd0, field_q[0]}, 8'h00);
        step(RA, 1'b1, 8'h01, 8'h00, 8'h00);
        check("R3 write one ignored", {7'd0, field_q[0]}, 8'h00);
        step(RA, 1'b0, 8'h00, 8'h01, 8'h01);
        check("R3 set wins over clear", {7'd0, field_q[0]}, 8'h01);
    endtask

    task automatic t_rw();
        logic [7:0] v;
        do_reset();
        step(RA, 1'b1, 8'h02, 8'h00, 8'h00);
        check("R4 write one", {7'd0, field_q[1]}, 8'h01);
        step(RA, 1'b0, 8'h00, 8'h00, 8'h02);
        check("R4 hw clear ignored", {7'd0, field_q[1]}, 8'h01);
        rd(RA, 1'b1, v);
        check("R4 readback", {7'd0, v[1]}, 8'h01);
        step(RA, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R4 write zero", {7'd0, field_q[1]}, 8'h00);
        step(RA, 1'b0, 8'h00, 8'h02, 8'h00);
        check("R4 hw set ignored", {7'd0, field_q[1]}, 8'h00);
    endtask

    task automatic t_rwhclr();
        do_reset();
        step(RA, 1'b0, 8'h00, 8'h00, 8'h04);
        check("R5 hw clear", {7'd0, field_q[2]}, 8'h00);
        step(RA, 1'b1, 8'h04, 8'h00, 8'h04);
        check("R5 write beats hw clear", {7'd0, field_q[2]}, 8'h01);
        step(RA, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R5 write zero", {7'd0, field_q[2]}, 8'h00);
        step(RA, 1'b0, 8'h00, 8'h04, 8'h00);
        check("R5 hw set ignored", {7'd0, field_q[2]}, 8'h00);
    endtask

    task automatic t_rwsc();
        do_reset();
        step(RA, 1'b0, 8'h00, 8'h08, 8'h00);
        check("R6 hw set", {7'd0, field_q[3]}, 8'h01);
        step(RA, 1'b0, 8'h00, 8'h00, 8'h08);
        check("R6 hw clear", {7'd0, field_q[3]}, 8'h00);
        step(RA, 1'b1, 8'h00, 8'h08, 8'h00);
        check("R6 set beats write zero", {7'd0, field_q[3]}, 8'h01);
        step(RA, 1'b1, 8'h08, 8'h00, 8'h08);
        check("R6 write beats hw clear", {7'd0, field_q[3]}, 8'h01);
    endtask

    task automatic t_w1c();
        do_reset();
        step(RA, 1'b0, 8'h00, 8'h10, 8'h00);
        check("R7 hw set", {7'd0, field_q[4]}, 8'h01);
        step(RA, 1'b1, 8'h00, 8'h00, 8'h10);
        check("R7 write zero and hw clear ignored", {7'd0, field_q[4]}, 8'h01);
        step(RA, 1'b1, 8'h10, 8'h00, 8'h00);
        check("R7 write one clears", {7'd0, field_q[4]}, 8'h00);
        step(RA, 1'b1, 8'h10, 8'h10, 8'h00);
        check("R7 set beats clear", {7'd0, field_q[4]}, 8'h01);
    endtask

    task automatic t_w1s();
        do_reset();
        step(RA, 1'b0, 8'h00, 8'h20, 8'h00);
        check("R8 hw set ignored", {7'd0, field_q[5]}, 8'h00);
        step(RA, 1'b1, 8'h20, 8'h00, 8'h00);
        check("R8 write one sets", {7'd0, field_q[5]}, 8'h01);
        step(RA, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R8 write zero ignored", {7'd0, field_q[5]}, 8'h01);
        step(RA, 1'b0, 8'h00, 8'h00, 8'h20);
        check("R8 hw clear", {7'd0, field_q[5]}, 8'h00);
        step(RA, 1'b1, 8'h20, 8'h00, 8'h20);
        check("R8 write beats hw clear", {7'd0, field_q[5]}, 8'h01);
    endtask

    task automatic t_xclr();
        do_reset();
        step(RA, 1'b0, 8'h00, 8'h40, 8'h00);
        check("R9 hw set", {7'd0, field_q[6]}, 8'h01);
        step(RA, 1'b1, 8'h00, 8'h00, 8'h00);
        check("R9 write zero ignored", {7'd0, field_q[6]}, 8'h01);
        step(RA, 1'b0, 8'h00, 8'h00, 8'h40);
        check("R9 hw clear", {7'd0, field_q[6]}, 8'h00);
        step(RA, 1'b0, 8'h00, 8'h40, 8'h00);
        step(RA, 1'b1, 8'h40, 8'h00, 8'h00);
        check("R9 write one clears", {7'd0, field_q[6]}, 8'h00);
        step(RA, 1'b1, 8'h40, 8'h40, 8'h40);
        check("R9 set beats both clears", {7'd0, field_q[6]}, 8'h01);
    endtask

    task automatic t_wo();
        logic [7:0] v;
        do_reset();
        step(RA, 1'b1, 8'h80, 8'h00, 8'h00);
        check("R10 write stored", {7'd0, field_q[7]}, 8'h01);
        rd(RA, 1'b1, v);
        check("R10 reads zero", {7'd0, v[7]}, 8'h00);
        step(RA, 1'b0, 8'h00, 8'h00, 8'h80);
        check("R10 hw clear ignored", {7'd0, field_q[7]}, 8'h01);
    endtask

    task automatic t_timing();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        addr = RA; wr_en = 1'b1; wr_data = 8'h02; rd_en = 1'b1;
        #2;
        check("R11 field_q before edge", {7'd0, field_q[1]}, 8'h00);
        check("R11 rd_data before edge", {7'd0, rd_data[1]}, 8'h00);
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
        v = rd_data;
        rd_en = 1'b0;
        check("R11 field_q after edge", {7'd0, field_q[1]}, 8'h01);
        check("R11 rd_data after edge", {7'd0, v[1]}, 8'h01);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_addr();
        t_hwstat();
        t_rw();
        t_rwhclr();
        t_rwsc();
        t_w1c();
        t_w1s();
        t_xclr();
        t_wo();
        t_timing();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule